// File: doc/BRIEF.md
# Dual-Input Up/Down Binary Counter

This block is a 4-bit binary counter steered by two separate count inputs rather than a single clock and a direction bit. A rising transition on the up input advances the count by one, but only while the down input rests high. A rising transition on the down input retreats the count by one, but only while the up input rests high. Both count inputs are treated as slow signals. A fast system clock samples them through a two-stage synchronizer and detects their edges, and every state bit is then updated in the same clock cycle.

An active-low preset copies a 4-bit data word onto the count output at once and holds it there while the preset is held low. An active-high clear forces the count to zero at once and overrides both the preset and the count inputs. Two active-low outputs, carry and borrow, pulse while the count sits at its top or bottom value and the matching count input is in its low phase. The up and down inputs of the next stage can be wired straight to these outputs, so stages cascade without extra logic.

Top module: `dual_input_counter`

## Requirements
- R1: A rising edge on upIn while downIn is high increments countOut by one. The new value appears no later than the third rising system clock edge after the input rises (two synchronizer stages, then the state register).
- R2: A rising edge on downIn while upIn is high decrements countOut by one, with the same latency as R1.
- R3: Counting wraps: incrementing from 15 (4'b1111) gives 0, and decrementing from 0 gives 15.
- R4: While loadN is 0, countOut equals dataIn without waiting for a clock edge, and count edges have no effect. After loadN returns to 1, the loaded value is kept.
- R5: While clrIn is 1, countOut is 0 without waiting for a clock edge. This overrides loadN and both count inputs, and the synchronizer returns to its idle-high state.
- R6: borrowN is 0 exactly while countOut is 0 and the synchronized downIn is low. Otherwise it is 1.
- R7: carryN is 0 exactly while countOut is 15 and the synchronized upIn is low. Otherwise it is 1.
- R8: A rising edge on one count input while the other count input is low leaves countOut unchanged.
- R9: Rising edges on both count inputs detected in the same system clock cycle leave countOut unchanged.
- R10: With no qualifying count edge, no preset and no clear, countOut holds its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| clrIn | input | 1 | Asynchronous clear, active high |
| upIn | input | 1 | Count-up input, idle high, acts on its rising edge |
| downIn | input | 1 | Count-down input, idle high, acts on its rising edge |
| loadN | input | 1 | Asynchronous preset enable, active low |
| dataIn | input | 4 | Preset value |
| countOut | output | 4 | Current count |
| carryN | output | 1 | Low while the count is 15 and up is low |
| borrowN | output | 1 | Low while the count is 0 and down is low |

## Verification
Several pairs of functions can fall in the same cycle. The pair that needs the most care is an up edge and a down edge arriving together. The bench provokes it by raising both count inputs on the same clock phase, so both synchronizers report their edges in the same cycle, and it expects the count to stay where it was. The bench also overlaps clear with preset, and preset with count pulses. It judges the outcome at the ports by the fixed priority: clear first, then preset, then counting.

// File: rtl/dual_counter_pkg.sv
package dual_counter_pkg;
  typedef struct packed {
    logic incr;
    logic decr;
    logic load;
  } ctlStrobes_t;
endpackage

// File: rtl/dual_counter_ctrl.sv
module dual_counter_ctrl
  import dual_counter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        clrIn,
  input  logic        upIn,
  input  logic        downIn,
  input  logic        loadN,
  output ctlStrobes_t strobes,
  output logic        upLvl,
  output logic        downLvl
);
  localparam int NCHAN = 2;
  localparam int LAST = SYNC_STAGES - 1;

  logic [NCHAN-1:0] rawIn;
  logic [NCHAN-1:0] lvl;
  logic [NCHAN-1:0] edgeSeen;

  assign rawIn = {downIn, upIn};

  // One synchronizer and one edge detector per count input.
  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic [SYNC_STAGES-1:0] pipe;
    logic prevLvl;

    always_ff @(posedge clk or posedge clrIn) begin
      if (clrIn) begin
        pipe    <= '1;
        prevLvl <= 1'b1;
      end else begin
        pipe    <= {pipe[SYNC_STAGES-2:0], rawIn[c]};
        prevLvl <= pipe[LAST];
      end
    end

    assign lvl[c]      = pipe[LAST];
    assign edgeSeen[c] = pipe[LAST] & ~prevLvl;
  end

  assign upLvl   = lvl[0];
  assign downLvl = lvl[1];

  always_comb begin
    strobes.load = ~loadN;
    strobes.incr = edgeSeen[0] & ~edgeSeen[1] & lvl[1] & loadN;
    strobes.decr = edgeSeen[1] & ~edgeSeen[0] & lvl[0] & loadN;
  end
endmodule

// File: rtl/dual_counter_dp.sv
module dual_counter_dp
  import dual_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrIn,
  input  ctlStrobes_t      strobes,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             upLvl,
  input  logic             downLvl,
  output logic [WIDTH-1:0] countOut,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] stateReg;

  always_ff @(posedge clk or posedge clrIn) begin
    if (clrIn)             stateReg <= '0;
    else if (strobes.load) stateReg <= dataIn;
    else if (strobes.incr) stateReg <= stateReg + ONE;
    else if (strobes.decr) stateReg <= stateReg - ONE;
  end

  // Clear and preset reach the output without waiting for a clock edge.
  always_comb begin
    if (clrIn)             countOut = '0;
    else if (strobes.load) countOut = dataIn;
    else                   countOut = stateReg;
  end

  assign carryN  = ~((countOut == TOP) & ~upLvl);
  assign borrowN = ~((countOut == '0) & ~downLvl);
endmodule

// File: rtl/dual_input_counter.sv
module dual_input_counter
  import dual_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clrIn,
  input  logic             upIn,
  input  logic             downIn,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] countOut,
  output logic             carryN,
  output logic             borrowN
);
  ctlStrobes_t strobes;
  logic        upLvl;
  logic        downLvl;

  dual_counter_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .clrIn(clrIn), .upIn(upIn), .downIn(downIn), .loadN(loadN),
    .strobes(strobes), .upLvl(upLvl), .downLvl(downLvl)
  );

  dual_counter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .clrIn(clrIn), .strobes(strobes), .dataIn(dataIn),
    .upLvl(upLvl), .downLvl(downLvl),
    .countOut(countOut), .carryN(carryN), .borrowN(borrowN)
  );
endmodule

// File: rtl/dual_counter_checker.sv
module dual_counter_checker
  import dual_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clrIn,
  input logic             loadN,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] countOut,
  input logic             carryN,
  input logic             borrowN,
  input ctlStrobes_t      strobes
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R5: clear dominates the output
  always @(posedge clk) begin
    if (clrIn === 1'b1) begin
      assert_clear_zero_R5: assert (countOut == '0);
    end
  end

  assert_load_passes_R4: assert property (@(posedge clk) disable iff (clrIn)
    !loadN |-> countOut == dataIn);

  assert_incr_step_R1: assert property (@(posedge clk) disable iff (clrIn)
    (strobes.incr && loadN) |=> (!loadN || countOut == $past(countOut) + WIDTH'(1)));

  assert_decr_step_R2: assert property (@(posedge clk) disable iff (clrIn)
    (strobes.decr && loadN) |=> (!loadN || countOut == $past(countOut) - WIDTH'(1)));

  assert_no_double_R9: assert property (@(posedge clk) disable iff (clrIn)
    !(strobes.incr && strobes.decr));

  assert_hold_R10: assert property (@(posedge clk) disable iff (clrIn)
    (!strobes.incr && !strobes.decr && loadN) |=> (!loadN || $stable(countOut)));

  assert_borrow_only_zero_R6: assert property (@(posedge clk) disable iff (clrIn)
    (countOut != '0) |-> borrowN);

  assert_carry_only_top_R7: assert property (@(posedge clk) disable iff (clrIn)
    (countOut != TOP) |-> carryN);
endmodule

bind dual_input_counter dual_counter_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clrIn(clrIn), .loadN(loadN), .dataIn(dataIn),
  .countOut(countOut), .carryN(carryN), .borrowN(borrowN), .strobes(strobes)
);

// File: tb/sim_dual_input_counter.sv
`timescale 1ns/1ps
module sim_dual_input_counter;
  logic       clk = 1'b0;
  logic       clrIn = 1'b1;
  logic       upIn = 1'b1;
  logic       downIn = 1'b1;
  logic       loadN = 1'b1;
  logic [3:0] dataIn = 4'h0;
  logic [3:0] countOut;
  logic       carryN;
  logic       borrowN;

  int total = 0;
  int bad = 0;
  logic [3:0] expCount = 4'h0;

  always #5 clk = ~clk;

  dual_input_counter u0 (
    .clk(clk), .clrIn(clrIn), .upIn(upIn), .downIn(downIn), .loadN(loadN),
    .dataIn(dataIn), .countOut(countOut), .carryN(carryN), .borrowN(borrowN)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseUp();
    upIn = 1'b0; settle(4);
    upIn = 1'b1; settle(4);
  endtask

  task automatic pulseDown();
    downIn = 1'b0; settle(4);
    downIn = 1'b1; settle(4);
  endtask

  task automatic testReset();
    check("R5 reset count", countOut, 0);
    check("R6 reset borrow", borrowN, 1);
    check("R7 reset carry", carryN, 1);
    clrIn = 1'b0; settle(2);
    check("R10 idle hold", countOut, 0);
  endtask

  task automatic testCountUp();
    for (int i = 0; i < 3; i++) begin
      pulseUp(); expCount++;
      check("R1 increment", countOut, expCount);
    end
    // latency: visible within three edges
    upIn = 1'b0; settle(4);
    upIn = 1'b1;
    repeat (3) @(posedge clk);
    #1; expCount++;
    check("R1 latency", countOut, expCount);
    settle(2);
  endtask

  task automatic testCountDown();
    pulseDown(); expCount--;
    check("R2 decrement", countOut, expCount);
    pulseDown(); expCount--;
    check("R2 decrement again", countOut, expCount);
  endtask

  task automatic testWrapAndCarry();
    loadN = 1'b0; dataIn = 4'd14; #1;
    check("R4 load immediate", countOut, 14);
    settle(1); loadN = 1'b1; settle(1);
    check("R4 load kept", countOut, 14);
    pulseUp();
    check("R1 to top", countOut, 15);
    upIn = 1'b0; settle(4);
    check("R7 carry low", carryN, 0);
    check("R6 borrow high at top", borrowN, 1);
    upIn = 1'b1; settle(4);
    check("R3 wrap up", countOut, 0);
    check("R7 carry released", carryN, 1);
    downIn = 1'b0; settle(4);
    check("R6 borrow low", borrowN, 0);
    check("R7 carry high at zero", carryN, 1);
    downIn = 1'b1; settle(4);
    check("R3 wrap down", countOut, 15);
    check("R6 borrow released", borrowN, 1);
    expCount = 4'd15;
  endtask

  task automatic testGated();
    downIn = 1'b0; settle(4);
    pulseUp();
    check("R8 up blocked by low down", countOut, expCount);
    downIn = 1'b1; settle(4); expCount--;
    check("R2 down after blocked up", countOut, expCount);
    upIn = 1'b0; downIn = 1'b0; settle(4);
    upIn = 1'b1; downIn = 1'b1; settle(4);
    check("R9 simultaneous edges", countOut, expCount);
  endtask

  task automatic testPriority();
    loadN = 1'b0; dataIn = 4'd9; #1;
    check("R4 preset", countOut, 9);
    dataIn = 4'd5; #1;
    check("R4 follows data", countOut, 5);
    pulseUp();
    check("R4 count ignored in load", countOut, 5);
    clrIn = 1'b1; #1;
    check("R5 clear over load", countOut, 0);
    settle(1);
    clrIn = 1'b0; #1;
    check("R4 load after clear", countOut, 5);
    settle(1); loadN = 1'b1; settle(1);
    pulseUp();
    check("R1 after load", countOut, 6);
    #2; clrIn = 1'b1; #1;
    check("R5 async clear", countOut, 0);
    upIn = 1'b0; settle(1); upIn = 1'b1; settle(3);
    check("R5 count ignored in clear", countOut, 0);
    clrIn = 1'b0; settle(3);
    check("R10 hold after clear", countOut, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle(3);
    testReset();
    testCountUp();
    testCountDown();
    testWrapAndCarry();
    testGated();
    testPriority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule